// File: doc/BRIEF.md
# Dual-Port Memory with Contention Arbitration and Busy-Gated Writes

This block is a 2048-word by 8-bit memory with two equal ports, left and right. Each port has its own active-low select, active-low read/write, active-low output enable, an 11-bit address, write data and registered read data with a valid flag. Either port may read or write any word at any time. When both ports select the same word, only one of them is allowed to write. The other side sees its busy flag pulled low, and any write it attempts is dropped inside the block.

A build parameter selects one of two roles. In the arbitrating role the block decides which side loses and drives both busy outputs. In the following role the busy pins are inputs and serve only as write inhibits for their side. A wider word is built from one arbitrating instance and any number of following instances whose busy inputs are wired to the arbitrating instance's busy outputs. Every byte lane then obeys the same decision, and a contended word is never split between the two ports.

Top module: `dpram_busy_gate`

## Requirements
- R1: After synchronous reset, both read-valid flags are 0, both read data buses are 0 and both busy outputs are high.
- R2: With select low and read/write low, the input data is stored at the addressed word on the rising edge. With select low, read/write high and output enable low, the stored word appears on read data with valid high one cycle after the address. A read sees the memory as it was before that edge's writes.
- R3: With select high, the port writes nothing, and one cycle later its valid flag is 0 and its read data is 0.
- R4: A read with output enable high gives valid 0 and read data 0 one cycle later.
- R5: In the arbitrating role, contention means both selects are low with equal addresses. If one side's select and address were already the same in the previous cycle and the other side's were not, the earlier side wins. Otherwise the left side wins. The loser's busy output is low for the whole contention. The decision is held while the contention lasts, and both busy outputs are never low together.
- R6: A write from a side whose busy is low is dropped and leaves the addressed word unchanged.
- R7: In the following role, busy inputs only gate writes on their own side, and both busy outputs stay high. Reads are never blocked by busy.
- R8: A write held active while its side is busy completes on the first edge at which that side's busy is high.
- R9: When both sides write the same word in the same cycle and neither is busy, the left side's data is stored.
- R10: In a width-expanded pair (one arbitrating and one following instance that shares its busy signals), every stored word holds both bytes from the same port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and read registers update on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| l_cs_n | input | 1 | Left port select, active low |
| l_rw_n | input | 1 | Left port direction: 1 read, 0 write |
| l_oe_n | input | 1 | Left port output enable, active low |
| l_addr | input | 11 | Left port word address |
| l_wdata | input | 8 | Left port write data |
| l_busy_in_n | input | 1 | Left busy input (used only in the following role), active low |
| l_rdata | output | 8 | Left port read data, 0 when not valid |
| l_rvalid | output | 1 | Left port read data valid |
| l_busy_out_n | output | 1 | Left busy output (arbitrating role), active low |
| r_cs_n | input | 1 | Right port select, active low |
| r_rw_n | input | 1 | Right port direction: 1 read, 0 write |
| r_oe_n | input | 1 | Right port output enable, active low |
| r_addr | input | 11 | Right port word address |
| r_wdata | input | 8 | Right port write data |
| r_busy_in_n | input | 1 | Right busy input (used only in the following role), active low |
| r_rdata | output | 8 | Right port read data, 0 when not valid |
| r_rvalid | output | 1 | Right port read data valid |
| r_busy_out_n | output | 1 | Right busy output (arbitrating role), active low |

## Verification
Busy outputs are combinational in the current port inputs plus one cycle of history. The bench checks them 1 ns after it drives new inputs, in the same cycle and before the edge. Writes take effect at the following rising edge. Read data and valid come from a register, so the result of a read presented in cycle n is checked at the falling edge of cycle n+1, before that cycle's new inputs are driven. The reference model computes the expected read value from its memory copy before it applies that cycle's writes, which gives the required read-before-write view.

// File: rtl/dpb_pkg.sv
// Shared constants and types for the busy-gated dual-port memory.
// Assumes exactly two ports, indexed left = 0 and right = 1.
package dpb_pkg;
    localparam int unsigned NUM_PORTS = 2;
    localparam int unsigned PORT_L    = 0;
    localparam int unsigned PORT_R    = 1;

    // Which side owns a contended word.
    typedef enum logic {
        WIN_LEFT  = 1'b0,
        WIN_RIGHT = 1'b1
    } winner_e;
endpackage

// File: rtl/dpb_arbiter.sv
// Contention arbiter for the arbitrating role.
// Flags contention when both ports are selected at the same address. The
// side whose request was already present in the previous cycle wins; on a
// tie the left side wins. The decision is held for as long as the
// contention lasts. Busy outputs are combinational so that they gate the
// write at the coming edge.
// Assumes synchronous active-low reset and port inputs stable around the edge.
module dpb_arbiter
    import dpb_pkg::*;
#(
    parameter int unsigned ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_cs_n,
    input  logic              r_cs_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              l_busy_n,
    output logic              r_busy_n
);
    logic              prev_l_cs_n;
    logic              prev_r_cs_n;
    logic [ADDR_W-1:0] prev_l_addr;
    logic [ADDR_W-1:0] prev_r_addr;
    logic              match_q;
    winner_e           win_q;

    logic              match;
    logic              l_early;
    logic              r_early;
    winner_e           win_now;

    // Detect contention and pick the winner for this cycle.
    always_comb begin
        match   = !l_cs_n && !r_cs_n && (l_addr == r_addr);
        l_early = !prev_l_cs_n && (prev_l_addr == l_addr);
        r_early = !prev_r_cs_n && (prev_r_addr == r_addr);
        if (match && match_q) begin
            win_now = win_q;
        end else if (r_early && !l_early) begin
            win_now = WIN_RIGHT;
        end else begin
            win_now = WIN_LEFT;
        end
    end

    // Drive busy low on the losing side only during contention.
    always_comb begin
        l_busy_n = !(match && (win_now == WIN_RIGHT));
        r_busy_n = !(match && (win_now == WIN_LEFT));
    end

    // Remember last cycle's requests and the held decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_l_cs_n <= 1'b1;
            prev_r_cs_n <= 1'b1;
            prev_l_addr <= '0;
            prev_r_addr <= '0;
            match_q     <= 1'b0;
            win_q       <= WIN_LEFT;
        end else begin
            prev_l_cs_n <= l_cs_n;
            prev_r_cs_n <= r_cs_n;
            prev_l_addr <= l_addr;
            prev_r_addr <= r_addr;
            match_q     <= match;
            win_q       <= win_now;
        end
    end

    // R5: the two busy outputs are never low together.
    a_r5_busy_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!l_busy_n && !r_busy_n));

    // R5: during contention exactly one side is busy.
    a_r5_one_loser: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_cs_n && !r_cs_n && l_addr == r_addr) |-> (l_busy_n != r_busy_n));

    // R5: a decision against the left side holds while contention persists.
    a_r5_left_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_busy_n && !l_cs_n && !r_cs_n) ##1
        (!l_cs_n && !r_cs_n && l_addr == r_addr && $stable(l_addr))
        |-> !l_busy_n);

    // R5: a decision against the right side holds while contention persists.
    a_r5_right_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_busy_n && !l_cs_n && !r_cs_n) ##1
        (!l_cs_n && !r_cs_n && l_addr == r_addr && $stable(r_addr))
        |-> !r_busy_n);
endmodule

// File: rtl/dpb_array.sv
// Storage array with two write ports and two asynchronous read taps.
// Read taps show the contents before this edge's writes. When both write
// enables target the same word, the left write is applied last and wins.
// Assumes the enables are already gated by busy.
module dpb_array #(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              l_we,
    input  logic              r_we,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] l_wdata,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] l_rd,
    output logic [DATA_W-1:0] r_rd
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Apply writes; the left port goes second so it takes priority.
    always_ff @(posedge clk) begin
        if (r_we) begin
            mem[r_addr] <= r_wdata;
        end
        if (l_we) begin
            mem[l_addr] <= l_wdata;
        end
    end

    // Read taps for the per-port output registers.
    always_comb begin
        l_rd = mem[l_addr];
        r_rd = mem[r_addr];
    end
endmodule

// File: rtl/dpb_port.sv
// One port's control decode. Forms the busy-gated write enable and the
// registered read path: data and valid appear one cycle after a read
// with output enable low, and otherwise read data is forced to zero.
// Assumes busy_n is the effective busy for this side (arbiter or pin).
module dpb_port #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rw_n,
    input  logic              oe_n,
    input  logic              busy_n,
    input  logic [DATA_W-1:0] mem_rd,
    output logic              we,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    logic rd_en;

    // Decode the port request into write and read strobes.
    always_comb begin
        we    = !cs_n && !rw_n && busy_n;
        rd_en = !cs_n && rw_n && !oe_n;
    end

    // Register read data and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= rd_en;
            rdata  <= rd_en ? mem_rd : '0;
        end
    end

    // R2: an enabled read yields valid data one cycle later.
    a_r2_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && rw_n && !oe_n) |=> rvalid);

    // R3: a deselected port shows no data one cycle later.
    a_r3_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!rvalid && rdata == '0));

    // R4: output enable high masks the read one cycle later.
    a_r4_oe_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && rw_n && oe_n) |=> (!rvalid && rdata == '0));
endmodule

// File: rtl/dpram_busy_gate.sv
// Dual-port memory with busy-gated writes.
// IS_MASTER = 1: an internal arbiter drives the busy outputs, and the
// busy inputs are unused. IS_MASTER = 0: the busy inputs gate writes, and
// the busy outputs are held high. Read paths never depend on busy.
// Assumes a single clock and synchronous active-low reset.
module dpram_busy_gate
    import dpb_pkg::*;
#(
    parameter int unsigned ADDR_W    = 11,
    parameter int unsigned DATA_W    = 8,
    parameter bit          IS_MASTER = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_cs_n,
    input  logic              l_rw_n,
    input  logic              l_oe_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    input  logic              l_busy_in_n,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_rvalid,
    output logic              l_busy_out_n,
    input  logic              r_cs_n,
    input  logic              r_rw_n,
    input  logic              r_oe_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    input  logic              r_busy_in_n,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_rvalid,
    output logic              r_busy_out_n
);
    logic [NUM_PORTS-1:0] cs_n_v;
    logic [NUM_PORTS-1:0] rw_n_v;
    logic [NUM_PORTS-1:0] oe_n_v;
    logic [NUM_PORTS-1:0] busy_eff_n;
    logic [NUM_PORTS-1:0] we_v;
    logic [NUM_PORTS-1:0] rvalid_v;
    logic [DATA_W-1:0]    mem_rd_v [NUM_PORTS];
    logic [DATA_W-1:0]    rdata_v  [NUM_PORTS];

    assign cs_n_v = {r_cs_n, l_cs_n};
    assign rw_n_v = {r_rw_n, l_rw_n};
    assign oe_n_v = {r_oe_n, l_oe_n};

    // Pick the busy source according to the role.
    generate
        if (IS_MASTER) begin : g_master
            logic arb_l_busy_n;
            logic arb_r_busy_n;
            logic unused_busy_in;

            dpb_arbiter #(.ADDR_W(ADDR_W)) u_arb (
                .clk      (clk),
                .rst_n    (rst_n),
                .l_cs_n   (l_cs_n),
                .r_cs_n   (r_cs_n),
                .l_addr   (l_addr),
                .r_addr   (r_addr),
                .l_busy_n (arb_l_busy_n),
                .r_busy_n (arb_r_busy_n)
            );

            assign busy_eff_n     = {arb_r_busy_n, arb_l_busy_n};
            assign l_busy_out_n   = arb_l_busy_n;
            assign r_busy_out_n   = arb_r_busy_n;
            assign unused_busy_in = l_busy_in_n & r_busy_in_n;
        end else begin : g_slave
            assign busy_eff_n   = {r_busy_in_n, l_busy_in_n};
            assign l_busy_out_n = 1'b1;
            assign r_busy_out_n = 1'b1;
        end
    endgenerate

    // One control block per port.
    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            dpb_port #(.DATA_W(DATA_W)) u_port (
                .clk    (clk),
                .rst_n  (rst_n),
                .cs_n   (cs_n_v[p]),
                .rw_n   (rw_n_v[p]),
                .oe_n   (oe_n_v[p]),
                .busy_n (busy_eff_n[p]),
                .mem_rd (mem_rd_v[p]),
                .we     (we_v[p]),
                .rdata  (rdata_v[p]),
                .rvalid (rvalid_v[p])
            );

            // R6: no write is issued from a side whose effective busy is low.
            a_r6_busy_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
                !busy_eff_n[p] |-> !we_v[p]);
        end
    endgenerate

    dpb_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .l_we    (we_v[PORT_L]),
        .r_we    (we_v[PORT_R]),
        .l_addr  (l_addr),
        .r_addr  (r_addr),
        .l_wdata (l_wdata),
        .r_wdata (r_wdata),
        .l_rd    (mem_rd_v[PORT_L]),
        .r_rd    (mem_rd_v[PORT_R])
    );

    assign l_rdata  = rdata_v[PORT_L];
    assign r_rdata  = rdata_v[PORT_R];
    assign l_rvalid = rvalid_v[PORT_L];
    assign r_rvalid = rvalid_v[PORT_R];
endmodule

// File: tb/sim_dpram_busy_gate.sv
// Bench: u0 arbitrating (low byte) and u1 following (high byte) form a
// 16-bit pair; u2 is a following instance with bench-driven busy inputs.
module sim_dpram_busy_gate;
    localparam int AW = 11;
    localparam int DW = 8;
    localparam int NA = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          l_cs_n = 1'b1, l_rw_n = 1'b1, l_oe_n = 1'b1;
    logic          r_cs_n = 1'b1, r_rw_n = 1'b1, r_oe_n = 1'b1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [15:0]   l_wd = '0, r_wd = '0;
    logic          b2_l_n = 1'b1, b2_r_n = 1'b1;

    logic [DW-1:0] m_l_rd, m_r_rd, s_l_rd, s_r_rd, q_l_rd, q_r_rd;
    logic          m_l_rv, m_r_rv, s_l_rv, s_r_rv, q_l_rv, q_r_rv;
    logic          m_l_bz, m_r_bz, s_l_bz, s_r_bz, q_l_bz, q_r_bz;

    dpram_busy_gate #(.ADDR_W(AW), .DATA_W(DW), .IS_MASTER(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n),
        .l_cs_n(l_cs_n), .l_rw_n(l_rw_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
        .l_wdata(l_wd[7:0]), .l_busy_in_n(1'b1), .l_rdata(m_l_rd),
        .l_rvalid(m_l_rv), .l_busy_out_n(m_l_bz),
        .r_cs_n(r_cs_n), .r_rw_n(r_rw_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
        .r_wdata(r_wd[7:0]), .r_busy_in_n(1'b1), .r_rdata(m_r_rd),
        .r_rvalid(m_r_rv), .r_busy_out_n(m_r_bz));

    dpram_busy_gate #(.ADDR_W(AW), .DATA_W(DW), .IS_MASTER(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n),
        .l_cs_n(l_cs_n), .l_rw_n(l_rw_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
        .l_wdata(l_wd[15:8]), .l_busy_in_n(m_l_bz), .l_rdata(s_l_rd),
        .l_rvalid(s_l_rv), .l_busy_out_n(s_l_bz),
        .r_cs_n(r_cs_n), .r_rw_n(r_rw_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
        .r_wdata(r_wd[15:8]), .r_busy_in_n(m_r_bz), .r_rdata(s_r_rd),
        .r_rvalid(s_r_rv), .r_busy_out_n(s_r_bz));

    dpram_busy_gate #(.ADDR_W(AW), .DATA_W(DW), .IS_MASTER(1'b0)) u2 (
        .clk(clk), .rst_n(rst_n),
        .l_cs_n(l_cs_n), .l_rw_n(l_rw_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
        .l_wdata(l_wd[7:0]), .l_busy_in_n(b2_l_n), .l_rdata(q_l_rd),
        .l_rvalid(q_l_rv), .l_busy_out_n(q_l_bz),
        .r_cs_n(r_cs_n), .r_rw_n(r_rw_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
        .r_wdata(r_wd[7:0]), .r_busy_in_n(b2_r_n), .r_rdata(q_r_rd),
        .r_rvalid(q_r_rv), .r_busy_out_n(q_r_bz));

    int n_chk = 0;
    int n_err = 0;

    // Reference state
    logic [15:0]   pm [2**AW];
    logic [7:0]    qm [2**AW];
    logic          pv_l_cs_n = 1'b1, pv_r_cs_n = 1'b1;
    logic [AW-1:0] pv_l_a = '0, pv_r_a = '0;
    logic          pv_match = 1'b0, pv_winl = 1'b1;

    logic          have_exp = 1'b0;
    string         exp_tag;
    logic          e_lv, e_rv, e2_lv, e2_rv;
    logic [15:0]   e_ld, e_rd;
    logic [7:0]    e2_ld, e2_rd;
    string         cur_tag = "R2";

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One bus cycle: check last cycle's reads, drive, check busy, update model.
    task automatic step(input logic lcs, input logic lrw, input logic loe,
                        input logic [AW-1:0] la, input logic [15:0] ld,
                        input logic rcs, input logic rrw, input logic roe,
                        input logic [AW-1:0] ra, input logic [15:0] rd,
                        input logic b2l, input logic b2r);
        logic match, le, re, winl, bl, br;
        @(negedge clk);
        if (have_exp) begin
            chk(exp_tag, "pair L valid", {30'd0, s_l_rv, m_l_rv}, {30'd0, e_lv, e_lv});
            chk(exp_tag, "pair L data", {16'd0, s_l_rd, m_l_rd}, {16'd0, e_ld});
            chk(exp_tag, "pair R valid", {30'd0, s_r_rv, m_r_rv}, {30'd0, e_rv, e_rv});
            chk(exp_tag, "pair R data", {16'd0, s_r_rd, m_r_rd}, {16'd0, e_rd});
            chk(exp_tag, "u2 L", {23'd0, q_l_rv, q_l_rd}, {23'd0, e2_lv, e2_ld});
            chk(exp_tag, "u2 R", {23'd0, q_r_rv, q_r_rd}, {23'd0, e2_rv, e2_rd});
        end
        l_cs_n = lcs; l_rw_n = lrw; l_oe_n = loe; l_addr = la; l_wd = ld;
        r_cs_n = rcs; r_rw_n = rrw; r_oe_n = roe; r_addr = ra; r_wd = rd;
        b2_l_n = b2l; b2_r_n = b2r;
        #1;
        match = !lcs && !rcs && (la == ra);
        le = !pv_l_cs_n && (pv_l_a == la);
        re = !pv_r_cs_n && (pv_r_a == ra);
        if (match && pv_match) winl = pv_winl;
        else if (re && !le)    winl = 1'b0;
        else                   winl = 1'b1;
        bl = !(match && !winl);
        br = !(match && winl);
        chk(cur_tag, "master busy {L,R}", {30'd0, m_l_bz, m_r_bz}, {30'd0, bl, br});
        chk("R7", "follower busy outs", {28'd0, s_l_bz, s_r_bz, q_l_bz, q_r_bz}, 32'hF);
        // expected reads: memory before this edge's writes
        exp_tag = cur_tag;
        e_lv = !lcs && lrw && !loe;  e_rv = !rcs && rrw && !roe;
        e_ld = e_lv ? pm[la] : 16'd0; e_rd = e_rv ? pm[ra] : 16'd0;
        e2_lv = e_lv; e2_rv = e_rv;
        e2_ld = e_lv ? qm[la] : 8'd0; e2_rd = e_rv ? qm[ra] : 8'd0;
        have_exp = 1'b1;
        // writes: right first so the left wins a same-word tie
        if (!rcs && !rrw && br)  pm[ra] = rd;
        if (!lcs && !lrw && bl)  pm[la] = ld;
        if (!rcs && !rrw && b2r) qm[ra] = rd[7:0];
        if (!lcs && !lrw && b2l) qm[la] = ld[7:0];
        pv_l_cs_n = lcs; pv_r_cs_n = rcs; pv_l_a = la; pv_r_a = ra;
        pv_match = match; pv_winl = winl;
    endtask

    task automatic idle();
        step(1, 1, 1, 0, 0, 1, 1, 1, 0, 0, 1, 1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", "reset valids", {26'd0, m_l_rv, m_r_rv, s_l_rv, s_r_rv, q_l_rv, q_r_rv}, 32'd0);
        chk("R1", "reset data", {m_l_rd, m_r_rd, q_l_rd, q_r_rd}, 32'd0);
        chk("R1", "reset busy", {30'd0, m_l_bz, m_r_bz}, 32'd3);
        rst_n = 1'b1;

        // R2: fill then read back through the right port
        cur_tag = "R2";
        for (int i = 0; i < NA; i++)
            step(0, 0, 1, AW'(i), 16'h1100 + 16'(i * 17), 1, 1, 1, 0, 0, 1, 1);
        for (int i = 0; i < NA; i++)
            step(1, 1, 1, 0, 0, 0, 1, 0, AW'(i), 0, 1, 1);

        // R3: deselected write attempt, then readback
        cur_tag = "R3";
        step(1, 0, 0, 0, 16'hDEAD, 1, 1, 1, 0, 0, 1, 1);
        step(0, 1, 0, 0, 0, 1, 1, 1, 0, 0, 1, 1);

        // R4: read with output enable high
        cur_tag = "R4";
        step(0, 1, 1, 1, 0, 0, 1, 1, 2, 0, 1, 1);
        idle();

        // R5/R6/R8: left reads word 3 first, right writes it later
        cur_tag = "R5";
        step(0, 1, 0, 3, 0, 1, 1, 1, 0, 0, 1, 1);
        step(0, 1, 0, 3, 0, 0, 0, 1, 3, 16'hA5C3, 1, 1);
        cur_tag = "R6";
        step(0, 1, 0, 3, 0, 0, 0, 1, 3, 16'hA5C3, 1, 1);
        cur_tag = "R8";
        step(1, 1, 1, 0, 0, 0, 0, 1, 3, 16'hA5C3, 1, 1);
        step(1, 1, 1, 0, 0, 0, 1, 0, 3, 0, 1, 1);
        idle();

        // R5/R9/R10: simultaneous arrival, both write word 5
        cur_tag = "R10";
        step(0, 0, 1, 5, 16'h3C4B, 0, 0, 1, 5, 16'h7E81, 1, 1);
        cur_tag = "R9";
        step(0, 1, 0, 5, 0, 1, 1, 1, 0, 0, 1, 1);
        idle();

        // R7: follower busy blocks its write but not reads
        cur_tag = "R7";
        step(0, 0, 1, 6, 16'h5A96, 1, 1, 1, 0, 0, 0, 1);
        step(0, 1, 0, 6, 0, 0, 1, 0, 6, 0, 0, 0);
        idle();

        // Random traffic over a small address window
        cur_tag = "R10";
        for (int i = 0; i < 600; i++) begin
            step(($urandom % 4) == 0, $urandom % 2, ($urandom % 5) == 0,
                 AW'($urandom % NA), 16'($urandom),
                 ($urandom % 4) == 0, $urandom % 2, ($urandom % 5) == 0,
                 AW'($urandom % NA), 16'($urandom),
                 ($urandom % 4) != 0, ($urandom % 4) != 0);
        end
        idle();
        idle();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(100000 * 8);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule